// File: doc/BRIEF.md
# Byte Command Decoder with Response Bytes

This block pulls one-byte commands from a first-word-fall-through receive queue and carries each one out against two request/acknowledge ports: a 32-location parallel port bus with 4-bit data, and a byte-wide settings store. The top three bits of a command choose the operation. The low five bits are an argument, which may be data, a port/store address or a configuration sub-code. The block keeps a current address, an 8-bit mode word and a sampled 5-bit status word. Every reply goes to a transmitter as a byte whose top three bits identify what kind of reply it is.

At startup the mode word is read from store location 0x20. If the mode asks for it, all 32 ports are preloaded from the matching store locations. The block then announces itself with a ready byte. Configuration commands change the mode bits, save or clear the stored mode, request a sync report, or halt the block pending an external reset. An optional echo returns every command after its reply.

Top module: `cmdbyte_ctrl`

## Requirements
- R1: In reset, rx_pop, tx_valid, bus_req and nv_req are low. After reset the block reads store location 0x20 into the mode word. If mode bit 2 is set, it writes port p with the low 4 bits of store location p, for p from 31 down to 0 in that order; otherwise it makes no port write. It then sends 0xF5.
- R2: Commands are popped one at a time, only while rx_valid is high. No command is popped while a reply byte is unaccepted, while a bus or store request is open, or before the previous command has finished.
- R3: Opcode 000 reads the port at the current address and replies 0x00 OR the 4-bit data. Opcode 010 writes the low 4 argument bits to the port at the current address and sends no reply.
- R4: Opcode 100 loads the 5 argument bits into the current address. Port and store operations that follow use that address.
- R5: Opcode 001 reads store location (current address) and replies 0x20 OR its low 5 bits. Opcode 011 writes the 5 argument bits, zero-extended, to that location and sends no reply.
- R6: Opcode 101 replies 0x60 OR {st_nv_error, st_nv_busy, st_not_timeout, st_cts, st_tone} (bit 4 down to bit 0), taken from the status inputs one cycle earlier.
- R7: Opcode 110 sends exactly one byte, 0xC0 OR its argument. When mode bit 0 is set, every other command except the halt codes sends 0xC0 OR its argument after its own reply. The test of bit 0 uses the mode as updated by that command.
- R8: Opcode 111 with argument bit 4 set and argument bit 3 clear sets mode bit (argument bits 2:1) to argument bit 0: bit 0 echo, bit 1 rts_en, bit 2 preload, bit 3 autosync_en. rts_en and autosync_en follow mode bits 1 and 3.
- R9: 0xFC replies 0x20 OR mode[4:0]. 0xFD writes the mode word to store location 0x20. 0xFE writes 0x00 to store location 0x20.
- R10: 0xFB raises sync_req for one cycle. 0xF8, 0xF9, 0xFA and opcode 111 with argument bit 4 clear (other than 0xEA) change no mode bit, address or store location and send only the echo.
- R11: 0xEA and 0xFF raise reset_req for one cycle and send nothing. The block then pops no command and issues no request until rst.
- R12: While tx_valid is high and tx_ready low, tx_data stays stable. While a bus or store request is open and unacknowledged, its address, write flag and data stay stable. A reply byte always precedes its echo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive queue holds a command |
| rx_data | input | 8 | Command at the head of the queue |
| rx_pop | output | 1 | Consume the head command at this edge |
| tx_valid | output | 1 | Reply byte offered |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts the byte at this edge |
| bus_req | output | 1 | Port bus request open |
| bus_we | output | 1 | Port bus request is a write |
| bus_addr | output | 5 | Port number |
| bus_wdata | output | 4 | Port write data |
| bus_rdata | input | 4 | Port read data, valid with bus_ack |
| bus_ack | input | 1 | Port bus request completed |
| nv_req | output | 1 | Store request open |
| nv_we | output | 1 | Store request is a write |
| nv_addr | output | 6 | Store location |
| nv_wdata | output | 8 | Store write data |
| nv_rdata | input | 8 | Store read data, valid with nv_ack |
| nv_ack | input | 1 | Store request completed |
| st_tone | input | 1 | Status: tone being processed |
| st_cts | input | 1 | Status: clear-to-send copy |
| st_not_timeout | input | 1 | Status: no watchdog timeout |
| st_nv_busy | input | 1 | Status: store write in progress |
| st_nv_error | input | 1 | Status: store write error |
| rts_en | output | 1 | Mode bit 1 |
| autosync_en | output | 1 | Mode bit 3 |
| sync_req | output | 1 | One-cycle sync report request |
| reset_req | output | 1 | One-cycle full reset request |

## Verification
Replies to internal commands (address, status, loopback, mode) raise tx_valid three edges after the popping edge. Replies to bus and store commands come three edges after the acknowledging edge, and the bench models acknowledge after zero to two wait cycles. Because that latency varies, the scoreboard does not check for a fixed cycle. It pairs each accepted byte with the next expected item at the transfer itself, sampling valid and ready half a cycle away from the edge. Results that have no reply byte (port and store contents, mode outputs, pulse counts, pop counts) are checked only after the queue and the scoreboard have drained and a further settling margin has passed. A stall with tx_ready held low checks that tx_data stays stable and that only one pop occurs.

// File: rtl/cmdbyte_pkg.sv
package cmdbyte_pkg;

    localparam int ARG_W = 5;

    typedef enum logic [2:0] {
        OP_PORT_RD  = 3'b000,
        OP_STORE_RD = 3'b001,
        OP_PORT_WR  = 3'b010,
        OP_STORE_WR = 3'b011,
        OP_SET_ADDR = 3'b100,
        OP_STATUS   = 3'b101,
        OP_LOOP     = 3'b110,
        OP_CONFIG   = 3'b111
    } opcode_e;

    typedef struct packed {
        opcode_e          op;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef enum logic [3:0] {
        ST_BOOT, ST_BOOT_W, ST_INIT_RD, ST_INIT_RW, ST_INIT_WR, ST_INIT_WW,
        ST_HELLO, ST_IDLE, ST_EXEC, ST_WAIT_BUS, ST_WAIT_NV, ST_FINISH,
        ST_SEND, ST_HALT
    } fsm_e;

    localparam logic [2:0] HDR_STORE = 3'b001;
    localparam logic [2:0] HDR_STAT  = 3'b011;
    localparam logic [2:0] HDR_ECHO  = 3'b110;
    localparam logic [7:0] READY_BYTE = 8'hF5;
    localparam logic [7:0] HALT_CODE_A = 8'hEA;
    localparam logic [7:0] HALT_CODE_B = 8'hFF;

    localparam logic [3:0] SUB_SYNC  = 4'hB;
    localparam logic [3:0] SUB_SHOW  = 4'hC;
    localparam logic [3:0] SUB_SAVE  = 4'hD;
    localparam logic [3:0] SUB_CLEAR = 4'hE;

    localparam int MB_ECHO = 0;
    localparam int MB_RTS  = 1;
    localparam int MB_PRELOAD = 2;
    localparam int MB_SYNC = 3;

    function automatic logic [7:0] tag_byte(input logic [2:0] hdr, input logic [ARG_W-1:0] val);
        return {hdr, val};
    endfunction

    function automatic logic is_halt(input cmd_t c);
        return (c == cmd_t'(HALT_CODE_A)) || (c == cmd_t'(HALT_CODE_B));
    endfunction

    function automatic logic is_cfg_sub(input cmd_t c);
        return (c.op == OP_CONFIG) && c.arg[4] && !is_halt(c);
    endfunction

    function automatic logic cfg_touches_store(input cmd_t c);
        return is_cfg_sub(c) && ((c.arg[3:0] == SUB_SAVE) || (c.arg[3:0] == SUB_CLEAR));
    endfunction

endpackage

// File: rtl/cmdbyte_req_port.sv
module cmdbyte_req_port #(
    parameter int AW = 5,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_we,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] start_wdata,
    output logic          req,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    input  logic          ack,
    input  logic [DW-1:0] rdata,
    output logic          done,
    output logic [DW-1:0] rdata_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req     <= 1'b0;
            we      <= 1'b0;
            addr    <= '0;
            wdata   <= '0;
            done    <= 1'b0;
            rdata_q <= '0;
        end else begin
            done <= 1'b0;
            if (req && ack) begin
                req     <= 1'b0;
                done    <= 1'b1;
                rdata_q <= rdata;
            end else if (start && !req) begin
                req   <= 1'b1;
                we    <= start_we;
                addr  <= start_addr;
                wdata <= start_wdata;
            end
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(wdata))); // R12

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        done |-> !req); // R12

endmodule

// File: rtl/cmdbyte_tx_slot.sv
module cmdbyte_tx_slot (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       free
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (load) begin
            tx_valid <= 1'b1;
            tx_data  <= load_byte;
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    assign free = !tx_valid;

    AST_TX_STABLE: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R12

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        load |-> !tx_valid); // R12

endmodule

// File: rtl/cmdbyte_ctrl.sv
module cmdbyte_ctrl
    import cmdbyte_pkg::*;
#(
    parameter int PADDR_W  = 5,
    parameter int PDATA_W  = 4,
    parameter int NV_AW    = 6,
    parameter int NV_DW    = 8,
    parameter int MODE_LOC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               rx_pop,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    input  logic               tx_ready,
    output logic               bus_req,
    output logic               bus_we,
    output logic [PADDR_W-1:0] bus_addr,
    output logic [PDATA_W-1:0] bus_wdata,
    input  logic [PDATA_W-1:0] bus_rdata,
    input  logic               bus_ack,
    output logic               nv_req,
    output logic               nv_we,
    output logic [NV_AW-1:0]   nv_addr,
    output logic [NV_DW-1:0]   nv_wdata,
    input  logic [NV_DW-1:0]   nv_rdata,
    input  logic               nv_ack,
    input  logic               st_tone,
    input  logic               st_cts,
    input  logic               st_not_timeout,
    input  logic               st_nv_busy,
    input  logic               st_nv_error,
    output logic               rts_en,
    output logic               autosync_en,
    output logic               sync_req,
    output logic               reset_req
);

    localparam logic [NV_AW-1:0]   MODE_ADDR = NV_AW'(MODE_LOC);
    localparam logic [PADDR_W-1:0] TOP_PORT  = '1;

    fsm_e               state;
    cmd_t               cmd_q;
    logic [ARG_W-1:0]   cur_addr;
    logic [NV_DW-1:0]   mode;
    logic [4:0]         status_q;
    logic [7:0]         prim_byte;
    logic               prim_pend;
    logic               echo_pend;
    logic               force_echo;
    logic [PADDR_W-1:0] init_idx;
    logic               sync_q;
    logic               reset_q;

    logic               bus_start, bus_start_we, bus_done;
    logic [PADDR_W-1:0] bus_start_addr;
    logic [PDATA_W-1:0] bus_start_wdata, bus_rdq;
    logic               nv_start, nv_start_we, nv_done;
    logic [NV_AW-1:0]   nv_start_addr;
    logic [NV_DW-1:0]   nv_start_wdata, nv_rdq;

    logic               tx_free, tx_load;
    logic [7:0]         tx_load_byte;

    cmdbyte_req_port #(.AW(PADDR_W), .DW(PDATA_W)) u_bus (
        .clk(clk), .rst(rst),
        .start(bus_start), .start_we(bus_start_we),
        .start_addr(bus_start_addr), .start_wdata(bus_start_wdata),
        .req(bus_req), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .ack(bus_ack), .rdata(bus_rdata),
        .done(bus_done), .rdata_q(bus_rdq)
    );

    cmdbyte_req_port #(.AW(NV_AW), .DW(NV_DW)) u_nv (
        .clk(clk), .rst(rst),
        .start(nv_start), .start_we(nv_start_we),
        .start_addr(nv_start_addr), .start_wdata(nv_start_wdata),
        .req(nv_req), .we(nv_we), .addr(nv_addr), .wdata(nv_wdata),
        .ack(nv_ack), .rdata(nv_rdata),
        .done(nv_done), .rdata_q(nv_rdq)
    );

    cmdbyte_tx_slot u_tx (
        .clk(clk), .rst(rst),
        .load(tx_load), .load_byte(tx_load_byte),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .free(tx_free)
    );

    // Queue pop and transmit loading
    assign rx_pop       = (state == ST_IDLE) && rx_valid && tx_free;
    assign tx_load      = (state == ST_SEND) && tx_free && (prim_pend || echo_pend);
    assign tx_load_byte = prim_pend ? prim_byte : tag_byte(HDR_ECHO, cmd_q.arg);

    assign rts_en      = mode[MB_RTS];
    assign autosync_en = mode[MB_SYNC];
    assign sync_req    = sync_q;
    assign reset_req   = reset_q;

    // Request launch for both ports
    always_comb begin
        bus_start       = 1'b0;
        bus_start_we    = 1'b0;
        bus_start_addr  = '0;
        bus_start_wdata = '0;
        nv_start        = 1'b0;
        nv_start_we     = 1'b0;
        nv_start_addr   = '0;
        nv_start_wdata  = '0;
        unique case (state)
            ST_BOOT: begin
                nv_start      = 1'b1;
                nv_start_addr = MODE_ADDR;
            end
            ST_INIT_RD: begin
                nv_start      = 1'b1;
                nv_start_addr = NV_AW'(init_idx);
            end
            ST_INIT_WR: begin
                bus_start       = 1'b1;
                bus_start_we    = 1'b1;
                bus_start_addr  = init_idx;
                bus_start_wdata = nv_rdq[PDATA_W-1:0];
            end
            ST_EXEC: begin
                unique case (cmd_q.op)
                    OP_PORT_RD: begin
                        bus_start      = 1'b1;
                        bus_start_addr = PADDR_W'(cur_addr);
                    end
                    OP_PORT_WR: begin
                        bus_start       = 1'b1;
                        bus_start_we    = 1'b1;
                        bus_start_addr  = PADDR_W'(cur_addr);
                        bus_start_wdata = cmd_q.arg[PDATA_W-1:0];
                    end
                    OP_STORE_RD: begin
                        nv_start      = 1'b1;
                        nv_start_addr = NV_AW'(cur_addr);
                    end
                    OP_STORE_WR: begin
                        nv_start       = 1'b1;
                        nv_start_we    = 1'b1;
                        nv_start_addr  = NV_AW'(cur_addr);
                        nv_start_wdata = NV_DW'(cmd_q.arg);
                    end
                    OP_CONFIG: begin
                        if (cfg_touches_store(cmd_q)) begin
                            nv_start       = 1'b1;
                            nv_start_we    = 1'b1;
                            nv_start_addr  = MODE_ADDR;
                            nv_start_wdata = (cmd_q.arg[3:0] == SUB_SAVE) ? mode : '0;
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_BOOT;
            cmd_q      <= '0;
            cur_addr   <= '0;
            mode       <= '0;
            status_q   <= '0;
            prim_byte  <= '0;
            prim_pend  <= 1'b0;
            echo_pend  <= 1'b0;
            force_echo <= 1'b0;
            init_idx   <= '0;
            sync_q     <= 1'b0;
            reset_q    <= 1'b0;
        end else begin
            sync_q   <= 1'b0;
            reset_q  <= 1'b0;
            status_q <= {st_nv_error, st_nv_busy, st_not_timeout, st_cts, st_tone};
            unique case (state)
                ST_BOOT: state <= ST_BOOT_W;
                ST_BOOT_W: begin
                    if (nv_done) begin
                        mode     <= nv_rdq;
                        init_idx <= TOP_PORT;
                        state    <= nv_rdq[MB_PRELOAD] ? ST_INIT_RD : ST_HELLO;
                    end
                end
                ST_INIT_RD: state <= ST_INIT_RW;
                ST_INIT_RW: if (nv_done) state <= ST_INIT_WR;
                ST_INIT_WR: state <= ST_INIT_WW;
                ST_INIT_WW: begin
                    if (bus_done) begin
                        if (init_idx == '0) begin
                            state <= ST_HELLO;
                        end else begin
                            init_idx <= init_idx - 1'b1;
                            state    <= ST_INIT_RD;
                        end
                    end
                end
                ST_HELLO: begin
                    prim_byte <= READY_BYTE;
                    prim_pend <= 1'b1;
                    echo_pend <= 1'b0;
                    state     <= ST_SEND;
                end
                ST_IDLE: begin
                    if (rx_pop) begin
                        cmd_q      <= cmd_t'(rx_data);
                        force_echo <= 1'b0;
                        state      <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    state <= ST_FINISH;
                    unique case (cmd_q.op)
                        OP_PORT_RD, OP_PORT_WR:   state <= ST_WAIT_BUS;
                        OP_STORE_RD, OP_STORE_WR: state <= ST_WAIT_NV;
                        OP_SET_ADDR: cur_addr <= cmd_q.arg;
                        OP_STATUS: begin
                            prim_byte <= tag_byte(HDR_STAT, status_q);
                            prim_pend <= 1'b1;
                        end
                        OP_LOOP: force_echo <= 1'b1;
                        OP_CONFIG: begin
                            if (is_halt(cmd_q)) begin
                                reset_q <= 1'b1;
                                state   <= ST_HALT;
                            end else if (is_cfg_sub(cmd_q)) begin
                                if (!cmd_q.arg[3]) begin
                                    mode[cmd_q.arg[2:1]] <= cmd_q.arg[0];
                                end else if (cmd_q.arg[3:0] == SUB_SYNC) begin
                                    sync_q <= 1'b1;
                                end else if (cmd_q.arg[3:0] == SUB_SHOW) begin
                                    prim_byte <= tag_byte(HDR_STORE, mode[4:0]);
                                    prim_pend <= 1'b1;
                                end else if (cfg_touches_store(cmd_q)) begin
                                    state <= ST_WAIT_NV;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                ST_WAIT_BUS: begin
                    if (bus_done) begin
                        if (cmd_q.op == OP_PORT_RD) begin
                            prim_byte <= 8'(bus_rdq);
                            prim_pend <= 1'b1;
                        end
                        state <= ST_FINISH;
                    end
                end
                ST_WAIT_NV: begin
                    if (nv_done) begin
                        if (cmd_q.op == OP_STORE_RD) begin
                            prim_byte <= tag_byte(HDR_STORE, nv_rdq[4:0]);
                            prim_pend <= 1'b1;
                        end
                        state <= ST_FINISH;
                    end
                end
                ST_FINISH: begin
                    echo_pend <= force_echo || mode[MB_ECHO];
                    state     <= ST_SEND;
                end
                ST_SEND: begin
                    if (tx_free) begin
                        if (prim_pend)      prim_pend <= 1'b0;
                        else if (echo_pend) echo_pend <= 1'b0;
                        else                state     <= ST_IDLE;
                    end
                end
                ST_HALT: state <= ST_HALT;
                default: state <= ST_HALT;
            endcase
        end
    end

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> rx_valid); // R2

    AST_POP_WHEN_DRAINED: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (!tx_valid && !bus_req && !nv_req)); // R2

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> (!rx_pop && !tx_valid && !bus_req && !nv_req)); // R11

    AST_RESET_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req); // R11

    AST_SYNC_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> !sync_req); // R10

    AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && nv_req)); // R2

endmodule

// File: tb/sim_cmdbyte_ctrl.sv
module sim_cmdbyte_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid, rx_pop;
    logic [7:0] rx_data;
    logic       tx_valid, tx_ready;
    logic [7:0] tx_data;
    logic       bus_req, bus_we, bus_ack;
    logic [4:0] bus_addr;
    logic [3:0] bus_wdata, bus_rdata;
    logic       nv_req, nv_we, nv_ack;
    logic [5:0] nv_addr;
    logic [7:0] nv_wdata, nv_rdata;
    logic       st_tone, st_cts, st_not_timeout, st_nv_busy, st_nv_error;
    logic       rts_en, autosync_en, sync_req, reset_req;

    always #4 clk = ~clk;

    cmdbyte_ctrl u0 (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
        .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_ack(nv_ack),
        .st_tone(st_tone), .st_cts(st_cts), .st_not_timeout(st_not_timeout),
        .st_nv_busy(st_nv_busy), .st_nv_error(st_nv_error),
        .rts_en(rts_en), .autosync_en(autosync_en),
        .sync_req(sync_req), .reset_req(reset_req)
    );

    logic [3:0] bus_mem [32];
    logic [7:0] nv_mem  [64];
    logic [7:0] rxq [$];
    logic [7:0] expq [$];
    string      exptag [$];

    int  n_chk = 0, n_fail = 0;
    int  pops = 0, bus_wr_cnt = 0, first_wr = -1, prev_wr = 0, desc_bad = 0;
    int  resets_seen = 0, syncs_seen = 0, cyc = 0;
    int  bus_wait = 0, bus_serv = 0, nv_wait = 0, nv_serv = 0;
    bit  pop_pend = 0, hold = 0;
    logic [7:0] m_mode;
    logic [4:0] m_addr;
    localparam logic [4:0] STAT_BITS = 5'b10101;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [7:0] v, input string tag);
        expq.push_back(v);
        exptag.push_back(tag);
    endtask

    task automatic wait_idle();
        while (rxq.size() != 0 || expq.size() != 0) @(negedge clk);
        repeat (16) @(negedge clk);
    endtask

    // Driver: predicts replies from the requirements, then queues the command
    task automatic exec(input logic [7:0] b);
        logic [2:0] op;
        logic [4:0] a;
        bit halt, skip_echo;
        op = b[7:5];
        a  = b[4:0];
        halt = (b == 8'hEA) || (b == 8'hFF);
        skip_echo = halt;
        case (op)
            3'b000: push_exp({4'h0, bus_mem[m_addr]}, "R3 port read reply");
            3'b001: push_exp({3'b001, nv_mem[{1'b0, m_addr}][4:0]}, "R5 store read reply");
            3'b100: m_addr = a;
            3'b101: push_exp({3'b011, STAT_BITS}, "R6 status reply");
            3'b110: begin
                push_exp({3'b110, a}, "R7 loopback reply");
                skip_echo = 1;
            end
            3'b111: begin
                if (!halt && a[4]) begin
                    if (!a[3]) m_mode[a[2:1]] = a[0];
                    else if (a[3:0] == 4'hC) push_exp({3'b001, m_mode[4:0]}, "R9 mode reply");
                end
            end
            default: ;
        endcase
        if (!skip_echo && m_mode[0]) push_exp({3'b110, a}, "R7 echo after reply");
        rxq.push_back(b);
        wait_idle();
    endtask

    // Per-cycle environment: queue, transmitter, bus and store models, monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                pop_pend = 0;
                bus_ack  = 0;
                nv_ack   = 0;
            end else begin
                if (pop_pend) begin
                    rxq.delete(0);
                    pop_pend = 0;
                end
                if (bus_ack) bus_ack = 0;
                else if (bus_req) begin
                    if (bus_wait > 0) bus_wait--;
                    else begin
                        bus_ack   = 1;
                        bus_rdata = bus_mem[bus_addr];
                        if (bus_we) begin
                            bus_mem[bus_addr] = bus_wdata;
                            if (bus_wr_cnt == 0) first_wr = int'(bus_addr);
                            else if (int'(bus_addr) != prev_wr - 1) desc_bad++;
                            prev_wr = int'(bus_addr);
                            bus_wr_cnt++;
                        end
                        bus_wait = bus_serv % 3;
                        bus_serv++;
                    end
                end
                if (nv_ack) nv_ack = 0;
                else if (nv_req) begin
                    if (nv_wait > 0) nv_wait--;
                    else begin
                        nv_ack   = 1;
                        nv_rdata = nv_mem[nv_addr];
                        if (nv_we) nv_mem[nv_addr] = nv_wdata;
                        nv_wait = (nv_serv + 1) % 3;
                        nv_serv++;
                    end
                end
            end
            rx_valid = (rxq.size() > 0);
            rx_data  = rx_valid ? rxq[0] : 8'h00;
            tx_ready = !hold && (cyc % 4 != 1);
            cyc++;
            #1;
            if (!rst) begin
                if (rx_pop) begin
                    pop_pend = 1;
                    pops++;
                end
                if (tx_valid && tx_ready) begin
                    if (expq.size() == 0) chk(0, "R12 unexpected reply byte", tx_data, 0);
                    else begin
                        logic [7:0] e;
                        string t;
                        e = expq.pop_front();
                        t = exptag.pop_front();
                        chk(tx_data == e, t, tx_data, e);
                    end
                end
                if (reset_req) resets_seen++;
                if (sync_req)  syncs_seen++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", expq.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int p0;
        rst = 1;
        rx_valid = 0; rx_data = 0; tx_ready = 0;
        bus_ack = 0; bus_rdata = 0; nv_ack = 0; nv_rdata = 0;
        st_tone = 1; st_cts = 0; st_not_timeout = 1; st_nv_busy = 0; st_nv_error = 1;
        for (int i = 0; i < 32; i++) bus_mem[i] = 4'h0;
        for (int i = 0; i < 64; i++) nv_mem[i] = 8'((i * 37 + 5) & 255);
        nv_mem[32] = 8'h04;
        repeat (4) @(negedge clk);
        #3;
        chk(!tx_valid && !bus_req && !nv_req && !rx_pop, "R1 idle outputs in reset",
            {tx_valid, bus_req, nv_req, rx_pop}, 0);
        m_mode = 8'h04;
        m_addr = 5'd0;
        push_exp(8'hF5, "R1 ready byte after preload");
        @(negedge clk);
        rst = 0;
        wait_idle();

        // R1: preload order and content
        chk(bus_wr_cnt == 32, "R1 preload write count", bus_wr_cnt, 32);
        chk(first_wr == 31 && desc_bad == 0, "R1 preload descending order", first_wr, 31);
        begin
            int bad = 0;
            for (int i = 0; i < 32; i++) if (bus_mem[i] != nv_mem[i][3:0]) bad++;
            chk(bad == 0, "R1 preload contents", bad, 0);
        end
        chk(rts_en == 0 && autosync_en == 0, "R8 mode from store", {rts_en, autosync_en}, 0);

        // R3, R4: port write uses low nibble, port read returns it
        exec(8'h85);
        exec(8'h4A);
        chk(bus_mem[5] == 4'hA, "R3 port write data", bus_mem[5], 4'hA);
        exec(8'h56);
        chk(bus_mem[5] == 4'h6, "R3 port write drops arg bit 4", bus_mem[5], 4'h6);
        exec(8'h00);
        exec(8'h93);
        exec(8'h00);

        // R5: store write then read, and upper bits masked on read
        exec(8'h7B);
        chk(nv_mem[19] == 8'h1B, "R5 store write", nv_mem[19], 8'h1B);
        exec(8'h20);
        nv_mem[19] = 8'hE7;
        exec(8'h20);

        // R6, R7
        exec(8'hA0);
        exec(8'hC9);

        // R2: no second pop while the reply is stalled
        hold = 1;
        p0 = pops;
        push_exp({3'b011, STAT_BITS}, "R6 status reply under stall");
        push_exp(8'hC1, "R7 loopback reply after stall");
        rxq.push_back(8'hA0);
        rxq.push_back(8'hC1);
        repeat (20) @(negedge clk);
        #3;
        chk(pops - p0 == 1, "R2 single pop while reply pending", pops - p0, 1);
        chk(tx_valid && tx_data == 8'h75, "R12 stalled byte held", tx_data, 8'h75);
        hold = 0;
        wait_idle();

        // R7, R8: echo on
        exec(8'hF1);
        exec(8'h00);
        exec(8'hC4);
        exec(8'hF3);
        chk(rts_en == 1, "R8 rts enable", rts_en, 1);
        exec(8'hF7);
        chk(autosync_en == 1, "R8 autosync enable", autosync_en, 1);

        // R9
        exec(8'hFC);
        exec(8'hFD);
        chk(nv_mem[32] == 8'h0F, "R9 mode saved", nv_mem[32], 8'h0F);
        exec(8'hFE);
        chk(nv_mem[32] == 8'h00, "R9 mode cleared", nv_mem[32], 8'h00);

        // R10
        exec(8'hFB);
        chk(syncs_seen == 1, "R10 sync pulse", syncs_seen, 1);
        exec(8'hF9);
        exec(8'hE5);
        chk(rts_en == 1 && autosync_en == 1 && bus_mem[5] == 4'h6, "R10 no-op codes",
            {rts_en, autosync_en}, 3);
        exec(8'hFC);

        // R8: echo off takes effect on its own command
        exec(8'hF0);
        exec(8'hF2);
        exec(8'hF6);
        chk(rts_en == 0 && autosync_en == 0, "R8 rts and autosync off", {rts_en, autosync_en}, 0);

        // R11: halt code
        exec(8'hEA);
        chk(resets_seen == 1, "R11 reset pulse on 0xEA", resets_seen, 1);
        p0 = pops;
        rxq.push_back(8'hA0);
        repeat (40) @(negedge clk);
        chk(rxq.size() == 1 && pops == p0, "R11 no pop after halt", rxq.size(), 1);

        // R1, R7: restart with echo on and no preload
        @(negedge clk);
        rst = 1;
        rxq.delete();
        nv_mem[32] = 8'h01;
        bus_wr_cnt = 0;
        repeat (3) @(negedge clk);
        m_mode = 8'h01;
        m_addr = 5'd0;
        push_exp(8'hF5, "R1 ready byte without preload");
        rst = 0;
        wait_idle();
        chk(bus_wr_cnt == 0, "R1 no preload when mode bit 2 clear", bus_wr_cnt, 0);
        exec(8'hC5);
        exec(8'hA0);
        exec(8'hFF);
        chk(resets_seen == 2, "R11 reset pulse on 0xFF", resets_seen, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule